// File: doc/BRIEF.md
# Command Stream Opcode Decoder

The decoder takes one 32-bit command word per cycle in which `cmd_valid_i` is high. It sorts each word into a header or a payload word. A header's opcode in bits 31:28 sets how many payload words follow it and how those words are used. The block has no backpressure, so every valid word is consumed in the cycle it is presented.

Payload words become register writes. Each write carries the current class id, an offset and the data word. Depending on the command, the offset steps up by one per word, stays fixed, or follows the set bits of a write mask. Some commands produce a one-cycle side-band event instead of writes: an immediate write, a restart with its target address, a gather descriptor with its address word, and lock acquire or release. An unknown opcode or extend sub-opcode raises an error pulse.

Every output is registered. Results for a word accepted at clock edge k appear after edge k and stay valid for one cycle. Data fields keep their last value while their strobe is low.

Top module: `cmd_decoder`

## Requirements
- R1: While `rst_ni` is low, all strobes are low, the payload counter is empty and the current class is 0. The first word accepted after reset, or after any reset in mid-stream, is decoded as a header.
- R2: Each accepted word raises exactly one of `hdr_o` and `pay_o` in the next cycle. A word that arrives while payload is still owed is payload, whatever its bit pattern.
- R3: Opcode 0 (set-class) loads the class from bits 15:6 and a base offset from bits 27:16. Its payload count is the popcount of the mask in bits 5:0. The payload words are written in ascending mask-bit order to base+bit index. A zero mask only changes the class.
- R4: Opcode 1 (incrementing write) takes its offset from bits 27:16 and its count from bits 15:0. Payload word n is written to offset+n, modulo 4096.
- R5: Opcode 2 (non-incrementing write) writes every payload word to the single offset in bits 27:16, with the count taken from bits 15:0.
- R6: Opcode 3 (masked write) takes a 16-bit mask from bits 15:0. Its payload count is the popcount of that mask. Words are written in ascending set-bit order to offset+bit index.
- R7: Opcode 4 (immediate) writes bits 15:0, zero-extended, to offset bits 27:16 under the current class. It has no payload.
- R8: Opcode 5 (restart) pulses `restart_o` with address equal to the command word shifted left by 4 (32 bits kept). It has no payload and no write.
- R9: Opcode 6 (gather) expects exactly one payload word. On that word `gather_o` pulses with offset bits 27:16, insert bit 15, type bit 14 and count bits 13:0 from the header, plus the address word. No write is issued.
- R10: Opcode 14 (extend) decodes the sub-opcode in bits 27:24. Sub-opcode 0 pulses lock acquire and 1 pulses lock release, each with the index in bits 7:0. Any other sub-opcode pulses `err_o`.
- R11: Opcodes 7 to 13 and 15 pulse `err_o` for one cycle. They count as headers with no payload.
- R12: A cycle with `cmd_valid_i` low produces no strobe and leaves the decode state unchanged.
- R13: An incrementing or non-incrementing write with count 0 expects no payload. The next word is a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word present this cycle |
| cmd_word_i | input | 32 | Command word |
| hdr_o | output | 1 | Previous word was a header |
| pay_o | output | 1 | Previous word was payload |
| wr_en_o | output | 1 | Register write strobe |
| wr_class_o | output | 10 | Class id of the write |
| wr_offset_o | output | 12 | Register offset of the write |
| wr_data_o | output | 32 | Write data |
| restart_o | output | 1 | Restart event |
| restart_addr_o | output | 32 | Restart target address |
| gather_o | output | 1 | Gather event (on its address word) |
| gather_offset_o | output | 12 | Gather offset field |
| gather_insert_o | output | 1 | Gather insert flag |
| gather_type_o | output | 1 | Gather type flag |
| gather_count_o | output | 14 | Gather word count |
| gather_addr_o | output | 32 | Gather address word |
| lock_acq_o | output | 1 | Lock acquire event |
| lock_rel_o | output | 1 | Lock release event |
| lock_idx_o | output | 8 | Lock index |
| err_o | output | 1 | Unknown opcode or extend sub-opcode |

## Verification
The assertions check several rules on every cycle. Header and payload strobes never overlap, and a strobe never appears without an accepted word the cycle before. Side-band events are mutually exclusive, errors occur only on headers, and gathers occur only on payload. Inside the sequencer they also check that the owed count drops by one per payload word and that a fixed offset stays put. Only the bench's scenarios can show that offsets follow mask-bit order and wrap past 4095, and that field positions land where the requirements say. The same applies to a payload word that looks like an opcode being treated as data, to a zero count or zero mask returning straight to header decoding, and to a reset in mid-payload taking effect.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;
  localparam int WORD_W = 32;
  localparam int OFF_W  = 12;
  localparam int CLS_W  = 10;
  localparam int CNT_W  = 16;
  localparam int MASK_W = 16;
  localparam int IDX_W  = 8;
  localparam int GCNT_W = 14;
  localparam int LSB_W  = $clog2(MASK_W);

  localparam logic [3:0] OP_SETCL  = 4'h0;
  localparam logic [3:0] OP_INCR   = 4'h1;
  localparam logic [3:0] OP_FIXED  = 4'h2;
  localparam logic [3:0] OP_MASK   = 4'h3;
  localparam logic [3:0] OP_IMM    = 4'h4;
  localparam logic [3:0] OP_RESTRT = 4'h5;
  localparam logic [3:0] OP_GATHER = 4'h6;
  localparam logic [3:0] OP_EXT    = 4'he;

  typedef enum logic [1:0] {PM_INCR, PM_FIXED, PM_MASK, PM_ADDR} pmode_e;

  typedef struct packed {
    pmode_e              mode;
    logic [CNT_W-1:0]    cnt;
    logic [MASK_W-1:0]   mask;
    logic [OFF_W-1:0]    off;
    logic                set_cls;
    logic [CLS_W-1:0]    cls;
    logic                imm;
    logic                restart;
    logic                acq;
    logic                rel;
    logic                err;
  } hdr_t;

  function automatic logic [CNT_W-1:0] popcnt(input logic [MASK_W-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < MASK_W; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction
endpackage

// File: rtl/cmdd_lsb.sv
module cmdd_lsb #(
  parameter int W  = 16,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/cmdd_hdr_dec.sv
module cmdd_hdr_dec
  import cmdd_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              dec_o
);
  logic [3:0] op;
  assign op = word_i[31:28];

  always_comb begin
    dec_o      = '0;
    dec_o.mode = PM_INCR;
    dec_o.off  = word_i[27:16];
    unique case (op)
      OP_SETCL: begin
        dec_o.set_cls = 1'b1;
        dec_o.cls     = word_i[15:6];
        dec_o.mode    = PM_MASK;
        dec_o.mask    = MASK_W'(word_i[5:0]);
        dec_o.cnt     = popcnt(MASK_W'(word_i[5:0]));
      end
      OP_INCR: dec_o.cnt = word_i[15:0];
      OP_FIXED: begin
        dec_o.mode = PM_FIXED;
        dec_o.cnt  = word_i[15:0];
      end
      OP_MASK: begin
        dec_o.mode = PM_MASK;
        dec_o.mask = word_i[15:0];
        dec_o.cnt  = popcnt(word_i[15:0]);
      end
      OP_IMM:    dec_o.imm = 1'b1;
      OP_RESTRT: dec_o.restart = 1'b1;
      OP_GATHER: begin
        dec_o.mode = PM_ADDR;
        dec_o.cnt  = CNT_W'(1);
      end
      OP_EXT: begin
        if (word_i[27:24] == 4'h0)      dec_o.acq = 1'b1;
        else if (word_i[27:24] == 4'h1) dec_o.rel = 1'b1;
        else                            dec_o.err = 1'b1;
      end
      default: dec_o.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmdd_seq.sv
module cmdd_seq
  import cmdd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [WORD_W-1:0] word_i,
  input  hdr_t              dec_i,
  output logic              pay_o,
  output pmode_e            mode_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [CLS_W-1:0]  cls_o,
  output logic [15:0]       ghdr_o
);
  logic [CNT_W-1:0]  rem_q;
  pmode_e            mode_q;
  logic [OFF_W-1:0]  off_q;
  logic [MASK_W-1:0] mask_q;
  logic [CLS_W-1:0]  cls_q;
  logic [15:0]       ghdr_q;
  logic [LSB_W-1:0]  lsb;

  cmdd_lsb #(.W(MASK_W), .IW(LSB_W)) u_lsb (.vec_i(mask_q), .idx_o(lsb));

  assign pay_o  = (rem_q != '0);
  assign mode_o = mode_q;
  assign cls_o  = cls_q;
  assign ghdr_o = ghdr_q;
  assign off_o  = (mode_q == PM_MASK) ? off_q + OFF_W'(lsb) : off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      mode_q <= PM_INCR;
      off_q  <= '0;
      mask_q <= '0;
      cls_q  <= '0;
      ghdr_q <= '0;
    end else if (acc_i) begin
      if (pay_o) begin
        rem_q <= rem_q - CNT_W'(1);
        if (mode_q == PM_INCR) off_q <= off_q + OFF_W'(1);
        if (mode_q == PM_MASK) mask_q <= mask_q & (mask_q - MASK_W'(1));
      end else begin
        rem_q  <= dec_i.cnt;
        mode_q <= dec_i.mode;
        off_q  <= dec_i.off;
        mask_q <= dec_i.mask;
        ghdr_q <= word_i[15:0];
        if (dec_i.set_cls) cls_q <= dec_i.cls;
      end
    end
  end

  // R4
  rem_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && rem_q != '0) |=> rem_q == $past(rem_q) - CNT_W'(1));
  // R5
  fixed_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && rem_q != '0 && mode_q == PM_FIXED) |=> off_q == $past(off_q));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> (rem_q == $past(rem_q) && cls_q == $past(cls_q)));
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmdd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [31:0]       cmd_word_i,
  output logic              hdr_o,
  output logic              pay_o,
  output logic              wr_en_o,
  output logic [9:0]        wr_class_o,
  output logic [11:0]       wr_offset_o,
  output logic [31:0]       wr_data_o,
  output logic              restart_o,
  output logic [31:0]       restart_addr_o,
  output logic              gather_o,
  output logic [11:0]       gather_offset_o,
  output logic              gather_insert_o,
  output logic              gather_type_o,
  output logic [13:0]       gather_count_o,
  output logic [31:0]       gather_addr_o,
  output logic              lock_acq_o,
  output logic              lock_rel_o,
  output logic [7:0]        lock_idx_o,
  output logic              err_o
);
  hdr_t             dec;
  logic             in_pay;
  pmode_e           pmode;
  logic [OFF_W-1:0] poff;
  logic [CLS_W-1:0] cls;
  logic [15:0]      ghdr;

  cmdd_hdr_dec u_dec (.word_i(cmd_word_i), .dec_o(dec));

  cmdd_seq u_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_i (cmd_valid_i),
    .word_i(cmd_word_i),
    .dec_i (dec),
    .pay_o (in_pay),
    .mode_o(pmode),
    .off_o (poff),
    .cls_o (cls),
    .ghdr_o(ghdr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o <= 1'b0; pay_o <= 1'b0; wr_en_o <= 1'b0;
      wr_class_o <= '0; wr_offset_o <= '0; wr_data_o <= '0;
      restart_o <= 1'b0; restart_addr_o <= '0;
      gather_o <= 1'b0; gather_offset_o <= '0; gather_insert_o <= 1'b0;
      gather_type_o <= 1'b0; gather_count_o <= '0; gather_addr_o <= '0;
      lock_acq_o <= 1'b0; lock_rel_o <= 1'b0; lock_idx_o <= '0; err_o <= 1'b0;
    end else begin
      hdr_o      <= cmd_valid_i && !in_pay;
      pay_o      <= cmd_valid_i && in_pay;
      wr_en_o    <= 1'b0;
      restart_o  <= 1'b0;
      gather_o   <= 1'b0;
      lock_acq_o <= 1'b0;
      lock_rel_o <= 1'b0;
      err_o      <= 1'b0;
      if (cmd_valid_i && in_pay) begin
        if (pmode == PM_ADDR) begin
          gather_o        <= 1'b1;
          gather_offset_o <= poff;
          gather_insert_o <= ghdr[15];
          gather_type_o   <= ghdr[14];
          gather_count_o  <= ghdr[GCNT_W-1:0];
          gather_addr_o   <= cmd_word_i;
        end else begin
          wr_en_o     <= 1'b1;
          wr_class_o  <= cls;
          wr_offset_o <= poff;
          wr_data_o   <= cmd_word_i;
        end
      end else if (cmd_valid_i) begin
        if (dec.imm) begin
          wr_en_o     <= 1'b1;
          wr_class_o  <= cls;
          wr_offset_o <= dec.off;
          wr_data_o   <= {16'h0, cmd_word_i[15:0]};
        end
        if (dec.restart) begin
          restart_o      <= 1'b1;
          restart_addr_o <= {cmd_word_i[27:0], 4'h0};
        end
        if (dec.acq || dec.rel) lock_idx_o <= cmd_word_i[IDX_W-1:0];
        lock_acq_o <= dec.acq;
        lock_rel_o <= dec.rel;
        err_o      <= dec.err;
      end
    end
  end

  // R2
  hdr_pay_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_o && pay_o));
  // R12
  strobe_needs_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_o || pay_o) |-> $past(cmd_valid_i));
  // R11
  err_on_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> hdr_o);
  // R9
  gather_on_pay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gather_o |-> (pay_o && !wr_en_o));
  // R8
  restart_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> (hdr_o && !wr_en_o));
  // R10
  event_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lock_acq_o, lock_rel_o, restart_o, gather_o, err_o}));
endmodule

// File: tb/tb_cmd_decoder.sv
module tb_cmd_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic        hdr_o, pay_o, wr_en_o, restart_o, gather_o;
  logic        gather_insert_o, gather_type_o, lock_acq_o, lock_rel_o, err_o;
  logic [9:0]  wr_class_o;
  logic [11:0] wr_offset_o, gather_offset_o;
  logic [31:0] wr_data_o, restart_addr_o, gather_addr_o;
  logic [13:0] gather_count_o;
  logic [7:0]  lock_idx_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int m_rem = 0, m_mode = 0, m_off = 0, m_mask = 0, m_cls = 0;
  logic [31:0] m_ghdr = '0;
  // expected outputs
  int e_hdr, e_pay, e_wr, e_cls, e_off, e_rs, e_g, e_acq, e_rel, e_idx, e_err;
  int e_goff, e_gins, e_gtyp, e_gcnt;
  logic [31:0] e_data, e_raddr, e_gaddr;

  always #10 clk_i = ~clk_i;

  cmd_decoder dut (.*);

  task automatic chk(input string tag, input string f, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "hdr", 32'(hdr_o), 32'(e_hdr));
    chk(tag, "pay", 32'(pay_o), 32'(e_pay));
    chk(tag, "wr_en", 32'(wr_en_o), 32'(e_wr));
    chk(tag, "restart", 32'(restart_o), 32'(e_rs));
    chk(tag, "gather", 32'(gather_o), 32'(e_g));
    chk(tag, "acq", 32'(lock_acq_o), 32'(e_acq));
    chk(tag, "rel", 32'(lock_rel_o), 32'(e_rel));
    chk(tag, "err", 32'(err_o), 32'(e_err));
    if (e_wr != 0) begin
      chk(tag, "class", 32'(wr_class_o), 32'(e_cls));
      chk(tag, "offset", 32'(wr_offset_o), 32'(e_off));
      chk(tag, "data", wr_data_o, e_data);
    end
    if (e_rs != 0) chk(tag, "raddr", restart_addr_o, e_raddr);
    if (e_g != 0) begin
      chk(tag, "goff", 32'(gather_offset_o), 32'(e_goff));
      chk(tag, "gins", 32'(gather_insert_o), 32'(e_gins));
      chk(tag, "gtyp", 32'(gather_type_o), 32'(e_gtyp));
      chk(tag, "gcnt", 32'(gather_count_o), 32'(e_gcnt));
      chk(tag, "gaddr", gather_addr_o, e_gaddr);
    end
    if (e_acq != 0 || e_rel != 0) chk(tag, "lidx", 32'(lock_idx_o), 32'(e_idx));
  endtask

  task automatic clr_exp();
    e_hdr = 0; e_pay = 0; e_wr = 0; e_cls = 0; e_off = 0; e_rs = 0; e_g = 0;
    e_acq = 0; e_rel = 0; e_idx = 0; e_err = 0; e_goff = 0; e_gins = 0;
    e_gtyp = 0; e_gcnt = 0; e_data = '0; e_raddr = '0; e_gaddr = '0;
  endtask

  task automatic step(input bit v, input logic [31:0] w, input string tag);
    clr_exp();
    if (v) begin
      if (m_rem > 0) begin
        e_pay = 1;
        m_rem--;
        e_cls = m_cls;
        e_data = w;
        if (m_mode == 3) begin
          e_g = 1;
          e_goff = int'(m_ghdr[27:16]);
          e_gins = int'(m_ghdr[15]);
          e_gtyp = int'(m_ghdr[14]);
          e_gcnt = int'(m_ghdr[13:0]);
          e_gaddr = w;
        end else begin
          e_wr = 1;
          e_off = m_off;
          if (m_mode == 0) m_off = (m_off + 1) % 4096;
          if (m_mode == 2) begin
            int b = 0;
            while (((m_mask >> b) & 1) == 0) b++;
            e_off = (m_off + b) % 4096;
            m_mask = m_mask & ~(1 << b);
          end
        end
      end else begin
        e_hdr = 1;
        case (int'(w[31:28]))
          0: begin
            m_cls = int'(w[15:6]); m_mask = int'(w[5:0]);
            m_rem = $countones(w[5:0]); m_mode = 2; m_off = int'(w[27:16]);
          end
          1: begin m_mode = 0; m_rem = int'(w[15:0]); m_off = int'(w[27:16]); end
          2: begin m_mode = 1; m_rem = int'(w[15:0]); m_off = int'(w[27:16]); end
          3: begin
            m_mode = 2; m_mask = int'(w[15:0]); m_rem = $countones(w[15:0]);
            m_off = int'(w[27:16]);
          end
          4: begin
            e_wr = 1; e_cls = m_cls; e_off = int'(w[27:16]); e_data = {16'h0, w[15:0]};
          end
          5: begin e_rs = 1; e_raddr = w << 4; end
          6: begin m_mode = 3; m_rem = 1; m_ghdr = w; end
          14: begin
            if (w[27:24] == 4'h0) begin e_acq = 1; e_idx = int'(w[7:0]); end
            else if (w[27:24] == 4'h1) begin e_rel = 1; e_idx = int'(w[7:0]); end
            else e_err = 1;
          end
          default: e_err = 1;
        endcase
      end
    end
    cmd_valid_i = v;
    cmd_word_i = w;
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic do_reset();
    cmd_valid_i = 1'b0;
    rst_ni = 1'b0;
    m_rem = 0; m_cls = 0; m_mode = 0; m_off = 0; m_mask = 0;
    clr_exp();
    repeat (2) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    step(0, 32'h0, "R12");
    // R3 set-class with mask 100101, an idle cycle inside the payload
    step(1, {4'h0, 12'h010, 10'h155, 6'b100101}, "R3");
    step(1, 32'hA000_0001, "R3");
    step(0, 32'h0, "R12");
    step(1, 32'hA000_0002, "R3");
    step(1, 32'hA000_0003, "R3");
    // R7 immediate under class 0x155
    step(1, 32'h4020_BEEF, "R7");
    // R3 zero mask changes class only
    step(1, {4'h0, 12'h777, 10'h02A, 6'b000000}, "R3");
    step(1, 32'h4055_1234, "R3");
    // R4 incrementing with wrap past 4095
    step(1, 32'h1FFE_0003, "R4");
    step(1, 32'h1111_1111, "R4");
    step(1, 32'h2222_2222, "R4");
    step(1, 32'h3333_3333, "R4");
    // R5 fixed offset
    step(1, 32'h2033_0002, "R5");
    step(1, 32'hCAFE_0001, "R5");
    step(1, 32'hCAFE_0002, "R5");
    // R13 zero counts
    step(1, 32'h1040_0000, "R13");
    step(1, 32'h4041_0005, "R13");
    step(1, 32'h2040_0000, "R13");
    step(1, 32'h4042_0006, "R13");
    // R6 masked write, bits 0 and 15
    step(1, 32'h3100_8001, "R6");
    step(1, 32'h0BAD_0000, "R6");
    step(1, 32'h0BAD_000F, "R6");
    // R8 restart
    step(1, 32'h5123_4567, "R8");
    // R9 gather then its address word
    step(1, {4'h6, 12'h044, 1'b1, 1'b0, 14'h1234}, "R9");
    step(1, 32'hDEAD_BEE0, "R9");
    step(1, {4'h6, 12'hFFF, 1'b0, 1'b1, 14'h3FFF}, "R9");
    step(1, 32'h0000_0010, "R9");
    // R10 extend
    step(1, 32'hE000_0007, "R10");
    step(1, 32'hE100_00FF, "R10");
    step(1, 32'hE500_0001, "R10");
    // R11 unknown opcodes, each followed by a header
    for (int op = 7; op <= 15; op++) begin
      if (op != 14) begin
        step(1, {4'(op), 28'h0000_003}, "R11");
        step(1, 32'h4001_0001, "R11");
      end
    end
    // R2 payload that looks like opcodes
    step(1, 32'h1200_0002, "R2");
    step(1, 32'h6000_0000, "R2");
    step(1, 32'hE000_0003, "R2");
    // R1 reset in mid-payload
    step(1, 32'h1300_0005, "R1");
    step(1, 32'h1234_5678, "R1");
    do_reset();
    step(1, 32'h4050_00AA, "R1");
    step(0, 32'h0, "R12");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule